// File: doc/BRIEF.md
# Transmit Interframe Gap Deferral Timer

This block decides when a half-duplex Ethernet transmitter may begin a frame. It watches the carrier-sense input and counts bit times from a one-cycle bit tick, so it runs on a system clock faster than the line rate. The gap starts counting only after a transmission or a backoff has finished and carrier sense has gone low. The gap has two parts. During the first part, carrier activity cancels the count, and the block waits again for carrier to drop. During the second part, carrier activity is ignored.

When the whole gap has elapsed, the block raises a level permit. The transmitter starts its frame by presenting a pending frame while the permit is high. The permit is then withdrawn until a new completion event restarts the deferral. A status flag shows that a deferral is in progress. After reset the block acts as if a transmission has just ended, so the first frame also waits a full gap.

Top module: `tx_defer_timer`

## Requirements
- R1: After reset, deferring is 1 and txAllowed is 0, and the first frame still waits a full gap.
- R2: While crs stays high after a completion event, no bit ticks are counted, and txAllowed stays 0.
- R3: The count advances only on cycles where bitTick is 1. Cycles without a tick do not shorten the gap.
- R4: With crs low throughout, txAllowed rises on the clock edge that samples the 96th bit tick after carrier dropped.
- R5: If crs is 1 on any cycle before the 60th tick of the gap has been counted, the count is discarded. A full 96-tick gap then restarts after crs is low again. A pulse after 59 ticks restarts the gap.
- R6: Once 60 ticks have been counted, crs is ignored. A carrier pulse after 60 or 61 ticks leaves txAllowed rising after 96 ticks in total.
- R7: txAllowed is a level. It stays 1 until framePending is sampled 1 while it is 1. On the next cycle both txAllowed and deferring are 0, meaning a frame is in flight.
- R8: A txDone or backoffDone pulse, in any state, makes deferring 1 and txAllowed 0 on the next cycle, and a fresh gap begins.
- R9: framePending while txAllowed is 0 has no effect: the gap length is unchanged.
- R10: txAllowed and deferring are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitTick | input | 1 | One-cycle pulse per bit time |
| crs | input | 1 | Carrier sense from the line |
| txDone | input | 1 | Pulse: a transmission has ended |
| backoffDone | input | 1 | Pulse: a backoff period has ended |
| framePending | input | 1 | Transmitter has a frame to start |
| txAllowed | output | 1 | Level permit to start a frame |
| deferring | output | 1 | Gap deferral in progress |

## Verification
The embedded assertions check several rules on every cycle:
- the permit and the deferral flag are never high together;
- the count stays below the gap length and moves only on a tick;
- a carrier pulse in the sensitive window sends the control back to waiting;
- the permit rises only on a tick;
- a frame start or a completion pulse has its effect on the next cycle.

Only the bench scenarios show that the gap is exactly 96 ticks long, and that the two windows meet at 60 ticks. They also show the end-to-end effect of a carrier pulse at a chosen bit position (59, 60, 61 and random ones), and that a pending frame during deferral leaves the gap length unchanged.

// File: rtl/tx_defer_pkg.sv
package tx_defer_pkg;

  typedef enum logic [2:0] {
    ST_WAIT_LOW = 3'd0,
    ST_SENSE    = 3'd1,
    ST_BLIND    = 3'd2,
    ST_READY    = 3'd3,
    ST_BUSY     = 3'd4
  } deferState_t;

  typedef struct packed {
    logic clr;
    logic inc;
  } cntStrobe_t;

endpackage

// File: rtl/tx_defer_count.sv
module tx_defer_count
  import tx_defer_pkg::*;
#(
  parameter int SENSE_BITS = 60,
  parameter int BLIND_BITS = 36
) (
  input  logic       clk,
  input  logic       rstN,
  input  cntStrobe_t strobe,
  output logic       senseLast,
  output logic       gapLast
);
  localparam int GAP_BITS = SENSE_BITS + BLIND_BITS;
  localparam int CNT_W    = $clog2(GAP_BITS + 1);
  localparam logic [CNT_W-1:0] SENSE_END = CNT_W'(SENSE_BITS - 1);
  localparam logic [CNT_W-1:0] GAP_END   = CNT_W'(GAP_BITS - 1);

  logic [CNT_W-1:0] bitCnt;

  always_ff @(posedge clk) begin
    if (!rstN)           bitCnt <= '0;
    else if (strobe.clr) bitCnt <= '0;
    else if (strobe.inc) bitCnt <= bitCnt + 1'b1;
  end

  assign senseLast = (bitCnt == SENSE_END);
  assign gapLast   = (bitCnt == GAP_END);

  // R4
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= GAP_END);

  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.inc && !strobe.clr) |=> $stable(bitCnt));

endmodule

// File: rtl/tx_defer_ctrl.sv
module tx_defer_ctrl
  import tx_defer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitTick,
  input  logic       crs,
  input  logic       txDone,
  input  logic       backoffDone,
  input  logic       framePending,
  input  logic       senseLast,
  input  logic       gapLast,
  output cntStrobe_t strobe,
  output logic       txAllowed,
  output logic       deferring
);
  deferState_t state, stateNext;
  logic restart;

  assign restart = txDone | backoffDone;

  always_comb begin
    stateNext  = state;
    strobe.clr = 1'b0;
    strobe.inc = 1'b0;
    if (restart) begin
      stateNext  = ST_WAIT_LOW;
      strobe.clr = 1'b1;
    end else begin
      unique case (state)
        ST_WAIT_LOW: begin
          strobe.clr = 1'b1;
          if (!crs) stateNext = ST_SENSE;
        end
        ST_SENSE: begin
          if (crs) begin
            stateNext  = ST_WAIT_LOW;
            strobe.clr = 1'b1;
          end else if (bitTick) begin
            strobe.inc = 1'b1;
            if (senseLast) stateNext = ST_BLIND;
          end
        end
        ST_BLIND: begin
          if (bitTick) begin
            if (gapLast) begin
              stateNext  = ST_READY;
              strobe.clr = 1'b1;
            end else begin
              strobe.inc = 1'b1;
            end
          end
        end
        ST_READY: begin
          if (framePending) stateNext = ST_BUSY;
        end
        ST_BUSY: stateNext = ST_BUSY;
        default: begin
          stateNext  = ST_WAIT_LOW;
          strobe.clr = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_WAIT_LOW;
    else       state <= stateNext;
  end

  assign txAllowed = (state == ST_READY);
  assign deferring = (state == ST_WAIT_LOW) || (state == ST_SENSE) ||
                     (state == ST_BLIND);

  // R10
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({txAllowed, deferring}));

  // R5
  sense_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SENSE && crs && !restart) |=> (state == ST_WAIT_LOW));

  // R3
  ready_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txAllowed) |-> $past(bitTick));

  // R7
  start_drops_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txAllowed && framePending && !restart) |=> (!txAllowed && !deferring));

  // R8
  restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    restart |=> (deferring && !txAllowed));

  // R2
  wait_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT_LOW && crs && !restart) |=> (state == ST_WAIT_LOW));

endmodule

// File: rtl/tx_defer_timer.sv
module tx_defer_timer
  import tx_defer_pkg::*;
#(
  parameter int SENSE_BITS = 60,
  parameter int BLIND_BITS = 36
) (
  input  logic clk,
  input  logic rstN,
  input  logic bitTick,
  input  logic crs,
  input  logic txDone,
  input  logic backoffDone,
  input  logic framePending,
  output logic txAllowed,
  output logic deferring
);
  cntStrobe_t strobe;
  logic senseLast, gapLast;

  tx_defer_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .crs(crs),
    .txDone(txDone), .backoffDone(backoffDone), .framePending(framePending),
    .senseLast(senseLast), .gapLast(gapLast), .strobe(strobe),
    .txAllowed(txAllowed), .deferring(deferring)
  );

  tx_defer_count #(.SENSE_BITS(SENSE_BITS), .BLIND_BITS(BLIND_BITS)) count_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .senseLast(senseLast), .gapLast(gapLast)
  );

endmodule

// File: tb/tx_defer_timer_tb_top.sv
module tx_defer_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int GAP       = 96;
  localparam int SENSE_WIN = 60;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitTick = 1'b0, crs = 1'b0, txDone = 1'b0, backoffDone = 1'b0;
  logic framePending = 1'b0;
  logic txAllowed, deferring;
  int checks = 0, errors = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_defer_timer dut_i (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .crs(crs), .txDone(txDone),
    .backoffDone(backoffDone), .framePending(framePending),
    .txAllowed(txAllowed), .deferring(deferring)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles, expected under 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
      $finish;
    end
  end

  function automatic int expectTicks(int pulseAt);
    if (pulseAt < SENSE_WIN) return GAP;
    return GAP - pulseAt;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic giveTicks(int n);
    for (int i = 0; i < n; i++) begin
      bitTick = 1'b1;
      @(negedge clk);
      bitTick = 1'b0;
      idle(3);
    end
  endtask

  task automatic ticksToReady(output int n);
    n = 0;
    while (!txAllowed && n < 400) begin
      giveTicks(1);
      n++;
    end
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1;
    @(negedge clk);
    s = 1'b0;
    idle(2);
  endtask

  task automatic startFrame();
    framePending = 1'b1;
    @(negedge clk);
    framePending = 1'b0;
  endtask

  initial begin
    int n;
    int b;
    void'($urandom(32'h5EED));
    idle(3);
    // R1 reset state
    check("R1 deferring", deferring, 1);
    check("R1 txAllowed", txAllowed, 0);
    rstN = 1'b1;
    idle(2);
    ticksToReady(n);
    check("R1 first gap", n, GAP);

    // R7 level hold, then start
    idle(20);
    check("R7 hold", txAllowed, 1);
    startFrame();
    check("R7 allowed after start", txAllowed, 0);
    check("R7 deferring after start", deferring, 0);
    giveTicks(120);
    check("R7 busy ignores ticks", txAllowed, 0);

    // R8 txDone, R2 crs high blocks counting
    crs = 1'b1;
    pulse(txDone);
    check("R8 deferring", deferring, 1);
    giveTicks(150);
    check("R2 no count under crs", txAllowed, 0);
    crs = 1'b0;
    idle(2);
    // R3 idle cycles without ticks
    idle(500);
    check("R3 no tick no progress", txAllowed, 0);
    ticksToReady(n);
    check("R4 exact gap", n, GAP);

    // R8 from READY via backoffDone; R9 framePending ignored while deferring
    pulse(backoffDone);
    check("R8 backoff restart", txAllowed, 0);
    giveTicks(10);
    framePending = 1'b1;
    giveTicks(20);
    framePending = 1'b0;
    ticksToReady(n);
    check("R9 gap unchanged", n, GAP - 30);

    // R5 carrier at bit 59
    startFrame(); pulse(txDone);
    giveTicks(59); pulse(crs);
    ticksToReady(n);
    check("R5 restart at 59", n, GAP);
    // R6 carrier at 60 and 61
    startFrame(); pulse(txDone);
    giveTicks(60); pulse(crs);
    check("R6 still deferring", deferring, 1);
    ticksToReady(n);
    check("R6 ignore at 60", n, GAP - 60);
    startFrame(); pulse(txDone);
    giveTicks(61); pulse(crs);
    ticksToReady(n);
    check("R6 ignore at 61", n, GAP - 61);

    // random carrier positions
    for (int it = 0; it < 24; it++) begin
      startFrame();
      crs = 1'($urandom_range(0, 1));
      if (it % 2 == 0) pulse(txDone); else pulse(backoffDone);
      idle($urandom_range(0, 5));
      crs = 1'b0;
      idle(2);
      b = $urandom_range(0, GAP - 1);
      giveTicks(b);
      pulse(crs);
      ticksToReady(n);
      check(b < SENSE_WIN ? "R5 random" : "R6 random", n, expectTicks(b));
    end
    check("R10 flags", int'(txAllowed && deferring), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule